// File: doc/BRIEF.md
# Boundary Scan Register with Preload and External-Test Modes

This block is the serial test register that sits between a device's pads and its core. A TAP controller outside the block supplies decoded strobes for the capture, shift and update steps, plus two instruction selects. Each strobe is sampled on the rising edge of the test clock. When the sample/preload select is active, the chain can snapshot every pad and stream the snapshot out on the serial output. Meanwhile new bits stream in from the serial input and can be parked in a bank of update latches. Throughout this mode the pads and core stay wired straight through.

When the external-test select is active, the update latches take over. Output pads, pad-enable groups and the core-side input values all come from the latches. That lets a board tester both drive nets and feed the core from the chain. When no chain instruction is selected, the strobes do nothing and the data path stays direct. A low synchronous reset clears every latch and forces the direct path.

Cells are counted from the serial output: input cells first, then output cells, then one enable cell per output group.

Top module: `bsr_chain`

## Requirements
- R1: While `tap_rst_n` is low at a rising edge of `tck`, all shift stages and update latches clear. While `tap_rst_n` is low, the pads and core are connected directly even if `sel_extest` is high: `pad_out=core_out`, `pad_oe=core_oe`, `core_in=pad_in`.
- R2: On a rising edge with `capture_dr` high and a chain instruction selected, the shift stages load the pad values. Input cells load `pad_in`, output cells load the value on `pad_out`, and enable cells load `pad_oe`.
- R3: On a rising edge with `shift_dr` high and a chain instruction selected (and `capture_dr` low), every stage takes the value of its neighbour one step further from `tdo`, and the last stage takes `tdi`. `tdo` shows stage 0 and changes on the falling edge of `tck`.
- R4: The cell order is fixed. Stage k, for k below N_IN, holds `pad_in[k]`. Stage N_IN+j holds `pad_out[j]`. Stage N_IN+N_OUT+g holds `pad_oe[g]`. Stage k is the k-th bit to appear on `tdo` after a capture, counting from 0.
- R5: Capture and shift leave the update latches, the pads and `core_in` unchanged. The update latches load from the shift stages only on a rising edge with `update_dr` high and a chain instruction selected.
- R6: With `sel_preload` high and `sel_extest` low, capture, shift and update all work, and the data path stays direct at all times.
- R7: With `sel_extest` high, `pad_out[j]` equals output latch j and `pad_oe[g]` equals enable latch g. Enable latch g governs output pads g·(N_OUT/N_OE) up to (g+1)·(N_OUT/N_OE)−1.
- R8: With `sel_extest` high, `core_in[k]` equals input latch k and does not follow `pad_in`.
- R9: With neither select high, the capture, shift and update strobes are ignored. The chain and `tdo` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst_n | input | 1 | Synchronous active-low TAP reset |
| tdi | input | 1 | Serial data in |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| sel_preload | input | 1 | Sample/preload instruction decoded |
| sel_extest | input | 1 | External-test instruction decoded |
| tdo | output | 1 | Serial data out, falling-edge timed |
| pad_in | input | N_IN | Values arriving at input pads |
| core_in | output | N_IN | Input values presented to the core |
| core_out | input | N_OUT | Core's output values |
| core_oe | input | N_OE | Core's enable per output group |
| pad_out | output | N_OUT | Values sent to output pad drivers |
| pad_oe | output | N_OE | Enable per output pad group |

## Verification
The direct paths and the external-test multiplexers are combinational. The bench checks them one half cycle after the edge that changes their selects or latches. An update strobe changes the pads at the same rising edge, and they are sampled just after the following falling edge. A capture loads the stages at its rising edge, and the first captured bit appears on `tdo` at the next falling edge. Each later shift edge exposes the next bit at its own falling edge. The bench therefore drives every input just after a falling edge and reads every output one nanosecond after the next falling edge. Under external test it sweeps all 512 latch patterns of the default chain and computes each expected pad, core value and captured bit from the previous pattern.

// File: rtl/bsr_pkg.sv
// Shared definitions for the boundary scan register.
// Assumes the instruction selects come from a decoded instruction register.
package bsr_pkg;

    typedef enum logic [1:0] {
        BSR_FUNC    = 2'd0,   // chain idle, direct path
        BSR_PRELOAD = 2'd1,   // chain active, direct path
        BSR_EXTEST  = 2'd2    // chain active, latches drive pads and core
    } bsr_mode_e;

    // External test wins if both selects are raised.
    function automatic bsr_mode_e bsr_decode(input logic extest, input logic preload);
        if (extest)       return BSR_EXTEST;
        else if (preload) return BSR_PRELOAD;
        else              return BSR_FUNC;
    endfunction

endpackage

// File: rtl/bsr_cell.sv
// One boundary scan cell: a shift stage and a separate update latch.
// Assumes capture has priority over shift; update is independent of both.
module bsr_cell (
    input  logic tck,
    input  logic tap_rst_n,
    input  logic cap_en,
    input  logic shift_en,
    input  logic upd_en,
    input  logic cap_val,
    input  logic ser_in,
    output logic ser_q,
    output logic upd_q
);

    // Shift stage: load pad value on capture, neighbour value on shift.
    always_ff @(posedge tck) begin
        if (!tap_rst_n)    ser_q <= 1'b0;
        else if (cap_en)   ser_q <= cap_val;
        else if (shift_en) ser_q <= ser_in;
    end

    // Update latch: copy shift stage only on the update strobe.
    always_ff @(posedge tck) begin
        if (!tap_rst_n)  upd_q <= 1'b0;
        else if (upd_en) upd_q <= ser_q;
    end

    // Latch keeps its value unless an update is requested.
    p_upd_hold_r5: assert property (@(posedge tck) disable iff (!tap_rst_n)
        !upd_en |=> $stable(upd_q));

    // A shift without capture moves the neighbour bit in.
    p_shift_move_r3: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (shift_en && !cap_en) |=> (ser_q == $past(ser_in)));

endmodule

// File: rtl/bsr_pad_mux.sv
// Selects between the functional path and the update latches on both the
// pad side and the core side. Purely combinational.
module bsr_pad_mux
    import bsr_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int N_OUT = 4,
    parameter int N_OE  = 2
) (
    input  bsr_mode_e        mode,
    input  logic [N_IN-1:0]  pad_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OE-1:0]  core_oe,
    input  logic [N_IN-1:0]  upd_in,
    input  logic [N_OUT-1:0] upd_out,
    input  logic [N_OE-1:0]  upd_oe,
    output logic [N_IN-1:0]  core_in,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OE-1:0]  pad_oe
);

    // Route latches in external test, otherwise pass straight through.
    always_comb begin
        if (mode == BSR_EXTEST) begin
            core_in = upd_in;
            pad_out = upd_out;
            pad_oe  = upd_oe;
        end else begin
            core_in = pad_in;
            pad_out = core_out;
            pad_oe  = core_oe;
        end
    end

endmodule

// File: rtl/bsr_chain.sv
// Boundary scan register top. Cell 0 is next to tdo. Input cells come first,
// then output cells, then one enable cell per output group.
// Assumes the strobes and selects are decoded from the TAP controller
// and are stable around the rising edge of tck. N_OUT is a multiple of N_OE.
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int N_IN  = 3,
    parameter int N_OUT = 4,
    parameter int N_OE  = 2
) (
    input  logic             tck,
    input  logic             tap_rst_n,
    input  logic             tdi,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             sel_preload,
    input  logic             sel_extest,
    output logic             tdo,
    input  logic [N_IN-1:0]  pad_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OE-1:0]  core_oe,
    output logic [N_OUT-1:0] pad_out,
    output logic [N_OE-1:0]  pad_oe
);

    localparam int LEN    = N_IN + N_OUT + N_OE;
    localparam int OUT_LO = N_IN;
    localparam int OE_LO  = N_IN + N_OUT;

    bsr_mode_e        mode;
    logic             chain_act;
    logic [LEN-1:0]   cap_vec;
    logic [LEN-1:0]   chain;
    logic [LEN-1:0]   upd;

    // Mode decode; reset forces the direct path regardless of the selects.
    always_comb begin
        mode      = bsr_decode(sel_extest && tap_rst_n, sel_preload);
        chain_act = (mode != BSR_FUNC);
        cap_vec   = {pad_oe, pad_out, pad_in};
    end

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        logic nxt;
        if (i == LEN - 1) begin : g_last
            assign nxt = tdi;
        end else begin : g_mid
            assign nxt = chain[i+1];
        end
        bsr_cell u_cell (
            .tck      (tck),
            .tap_rst_n(tap_rst_n),
            .cap_en   (capture_dr && chain_act),
            .shift_en (shift_dr && chain_act),
            .upd_en   (update_dr && chain_act),
            .cap_val  (cap_vec[i]),
            .ser_in   (nxt),
            .ser_q    (chain[i]),
            .upd_q    (upd[i])
        );
    end

    bsr_pad_mux #(.N_IN(N_IN), .N_OUT(N_OUT), .N_OE(N_OE)) u_mux (
        .mode    (mode),
        .pad_in  (pad_in),
        .core_out(core_out),
        .core_oe (core_oe),
        .upd_in  (upd[N_IN-1:0]),
        .upd_out (upd[OE_LO-1:OUT_LO]),
        .upd_oe  (upd[LEN-1:OE_LO]),
        .core_in (core_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // Serial output retimed to the falling edge of tck.
    always_ff @(negedge tck) begin
        if (!tap_rst_n) tdo <= 1'b0;
        else            tdo <= chain[0];
    end

    // Reset clears every update latch.
    p_reset_clear_r1: assert property (@(posedge tck)
        !tap_rst_n |=> (upd == '0));

    // tdo presents stage 0 before each rising edge.
    p_tdo_stage0_r3: assert property (@(posedge tck) disable iff (!tap_rst_n)
        tdo == chain[0]);

    // Capture loads the input cells from the pads.
    p_capture_in_r2: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (capture_dr && chain_act) |=> (chain[N_IN-1:0] == $past(pad_in)));

    // With no chain instruction, the chain does not move.
    p_idle_hold_r9: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (!sel_preload && !sel_extest) |=> $stable(chain));

    // Outside external test, the pads follow the core.
    p_direct_pads_r6: assert property (@(posedge tck) disable iff (!tap_rst_n)
        !sel_extest |-> (pad_out == core_out && core_in == pad_in));

endmodule

// File: tb/bsr_chain_test.sv
module bsr_chain_test;

    localparam int N_IN  = 3;
    localparam int N_OUT = 4;
    localparam int N_OE  = 2;
    localparam int LEN   = N_IN + N_OUT + N_OE;

    logic tck = 1'b0;
    logic tap_rst_n, tdi, capture_dr, shift_dr, update_dr, sel_preload, sel_extest;
    logic tdo;
    logic [N_IN-1:0]  pad_in, core_in;
    logic [N_OUT-1:0] core_out, pad_out;
    logic [N_OE-1:0]  core_oe, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 tck = ~tck;

    bsr_chain #(.N_IN(N_IN), .N_OUT(N_OUT), .N_OE(N_OE)) uut (
        .tck(tck), .tap_rst_n(tap_rst_n), .tdi(tdi),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .sel_preload(sel_preload), .sel_extest(sel_extest), .tdo(tdo),
        .pad_in(pad_in), .core_in(core_in), .core_out(core_out),
        .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply strobes for one rising edge; return just after the falling edge.
    task automatic step(input logic c, input logic s, input logic u, input logic t);
        capture_dr = c; shift_dr = s; update_dr = u; tdi = t;
        @(posedge tck);
        @(negedge tck);
        #1;
        capture_dr = 0; shift_dr = 0; update_dr = 0;
    endtask

    // Capture, shift LEN bits in while collecting LEN bits out, then update.
    // Pads and core side are checked against the expected values while shifting.
    task automatic scan(input logic [LEN-1:0] din, output logic [LEN-1:0] cap,
                        input logic [N_OUT-1:0] hold_out, input logic [N_IN-1:0] hold_core);
        step(1, 0, 0, 0);
        for (int j = 0; j < LEN; j++) begin
            cap[j] = tdo;
            chk("R5 pad_out held during shift", int'(pad_out), int'(hold_out));
            chk("R5 core_in held during shift", int'(core_in), int'(hold_core));
            step(0, 1, 0, din[j]);
        end
        step(0, 0, 1, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] cap;
        logic [LEN-1:0] prev;
        logic [LEN-1:0] w;
        tap_rst_n = 0; tdi = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
        sel_preload = 0; sel_extest = 1;
        pad_in = 3'b110; core_out = 4'b1010; core_oe = 2'b01;
        step(0, 0, 0, 0);
        step(0, 0, 1, 0);
        // R1: reset forces the direct path even with external test selected
        chk("R1 pad_out direct in reset", int'(pad_out), 'hA);
        chk("R1 pad_oe direct in reset", int'(pad_oe), 1);
        chk("R1 core_in direct in reset", int'(core_in), 6);
        chk("R1 tdo cleared", int'(tdo), 0);
        sel_extest = 0;
        tap_rst_n = 1;
        step(0, 0, 0, 0);
        sel_extest = 1;
        #1;
        chk("R1 latches clear after reset", int'({pad_oe, pad_out, core_in}), 0);
        sel_extest = 0;

        // R9: no instruction selected, strobes have no effect
        pad_in = 3'b111;
        step(1, 0, 0, 0);
        chk("R9 capture ignored", int'(tdo), 0);
        step(0, 1, 0, 1);
        step(0, 0, 1, 1);
        chk("R9 shift ignored", int'(tdo), 0);
        sel_extest = 1;
        #1;
        chk("R9 update ignored", int'({pad_oe, pad_out, core_in}), 0);
        sel_extest = 0;
        #1;

        // R6, R2, R4: sample/preload sweep over all pad_in values
        sel_preload = 1;
        for (int p = 0; p < 8; p++) begin
            pad_in   = 3'(p);
            core_out = 4'((p * 5 + 3) & 15);
            core_oe  = 2'(p & 3);
            w        = LEN'((p * 37 + 11) & 511);
            scan(w, cap, core_out, pad_in);
            chk("R2 R4 R3 captured chain in order", int'(cap), int'({core_oe, core_out, pad_in}));
            chk("R6 pad_out direct after update", int'(pad_out), int'(core_out));
            chk("R6 pad_oe direct after update", int'(pad_oe), int'(core_oe));
            chk("R6 core_in direct after update", int'(core_in), int'(pad_in));
            prev = w;
        end

        // R7, R8: external test over every latch pattern
        sel_preload = 0;
        sel_extest  = 1;
        #1;
        chk("R7 preloaded outputs appear", int'(pad_out), int'(prev[N_IN+N_OUT-1:N_IN]));
        chk("R8 preloaded core inputs appear", int'(core_in), int'(prev[N_IN-1:0]));
        for (int v = 0; v < (1 << LEN); v++) begin
            pad_in = 3'(v) ^ 3'b101;
            scan(LEN'(v), cap, prev[N_IN+N_OUT-1:N_IN], prev[N_IN-1:0]);
            chk("R2 R4 capture under extest", int'(cap),
                int'({prev[LEN-1:N_IN], 3'(v) ^ 3'b101}));
            w = LEN'(v);
            chk("R7 pad_out from latches", int'(pad_out), int'(w[N_IN+N_OUT-1:N_IN]));
            chk("R7 pad_oe group from latches", int'(pad_oe), int'(w[LEN-1:N_IN+N_OUT]));
            chk("R8 core_in from latches", int'(core_in), int'(w[N_IN-1:0]));
            prev = w;
        end

        // R1: reset during external test returns to the direct path
        tap_rst_n = 0;
        step(0, 0, 0, 0);
        chk("R1 direct on second reset", int'(pad_out), int'(core_out));
        tap_rst_n = 1;
        step(0, 0, 0, 0);
        chk("R1 latches cleared on second reset", int'({pad_oe, pad_out, core_in}), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule